// File: doc/BRIEF.md
# Parallel Printer Port with Built-in Printer Handshake

This block is a byte-wide, register-mapped printer port. A host writes a data byte, then toggles bits of a control register to present it. The far end is not an external device. A small model of a printer inside the block answers the host, and each byte it accepts goes out on a valid/ready byte stream for a downstream consumer.

A rising edge of the strobe control bit hands the byte to the stream while the printer is selected and not held in initialisation. Reads of the status register then walk the printer through its acknowledge and ready steps. The acknowledge step can raise an interrupt when interrupts are enabled. A direction bit makes a read of the data register return an externally supplied input byte in place of the last written byte.

Top module: `lpt_port`

## Requirements
- R1: After reset, a status read returns 0xD8 and a control read returns 0xCC. `irq` is 0 and `tx_valid` is 0.
- R2: Status layout: bit 7 is ready (the inverted busy sense, 1 = idle). Bit 6 is acknowledge and bit 5 is paper-out, which always reads 0. Bit 4 is online, bit 3 is the inverted error sense (1 = no error), and bits 2 to 0 read 0.
- R3: Control layout: bit 5 is direction (1 = read the input byte), bit 4 is interrupt enable, bit 3 is select, bit 2 is the inverted init sense, bit 1 is auto-linefeed and bit 0 is strobe. Bits 5 to 0 read back as written and bits 7 and 6 read 1.
- R4: A control write with bit 2 at 0 reloads status to 0xD8. It sends no byte, even when it raises strobe.
- R5: A control write with bits 2, 3 and 0 all at 1 clears status bit 7. If the previous control value had bit 0 at 0, the current data byte is also loaded onto the stream. A write that keeps strobe at 1 sends nothing.
- R6: A status read returns the value held before the read. The read advances the handshake when status bit 7 is 0, control bit 0 is 0 and no byte is pending. If bit 6 is 1, the read clears it and sets the pending-interrupt flag. Otherwise the read sets bits 6 and 7.
- R7: A pending byte keeps `tx_valid` at 1 and `tx_data` unchanged until `tx_ready` is 1. While a byte is pending, status reads do not advance the handshake, and this includes a read in the cycle the byte is taken. A strobe edge while a byte is pending is dropped, unless the pending byte is taken in that same cycle, in which case the new byte becomes pending.
- R8: `irq` is the interrupt enable AND the pending flag, updated in the cycle of the access. A status read that does not perform the acknowledge step clears the flag. A change of the enable bit does not clear the flag.
- R9: A data read returns `pin_in` when control bit 5 is 1, and the last written data byte otherwise.
- R10: Offsets 3 to 7 read 0xFF, and writes to them change no other register.
- R11: `rdata` carries the addressed value from the cycle after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Input byte returned in read direction |
| tx_valid | output | 1 | Output stream byte valid |
| tx_data | output | 8 | Output stream byte |
| tx_ready | input | 1 | Consumer accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions get their own test. In the first, the consumer takes a pending byte in the same cycle as a control write that raises strobe. That is provoked by asserting `tx_ready` together with that write, and it is judged by the first byte being counted as delivered while the second becomes the new pending byte. In the second, a status read lands in the very cycle the pending byte is taken. The next status read must show the unadvanced value, which proves the earlier read saw the byte as still pending.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int OFF_DATA = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_CTRL = 2;

  localparam int CTRL_W = 6;

  localparam int ST_BUSY = 7;
  localparam int ST_ACK  = 6;

  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [7:0]        ST_IDLE  = 8'hD8;
  localparam logic [CTRL_W-1:0] CT_RESET = 6'h0C;
endpackage

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
  import lpt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ien_nxt,
  output logic              init_low,
  output logic              busy_clr,
  output logic              strobe_rise
);
  // Decode of a control write against the value it replaces
  always_comb begin
    init_low    = wr_ctrl & ~wdata[CT_INIT];
    busy_clr    = wr_ctrl & wdata[CT_INIT] & wdata[CT_SEL] & wdata[CT_STB];
    strobe_rise = busy_clr & ~ctrl_q[CT_STB];
    ien_nxt     = wr_ctrl ? wdata[CT_IEN] : ctrl_q[CT_IEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctrl_q <= CT_RESET;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end
endmodule

// File: rtl/lpt_byte_out.sv
module lpt_byte_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_rise,
  input  logic [DATA_W-1:0] data_q,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  logic slot_free;
  logic load;

  always_comb begin
    slot_free = ~tx_valid | tx_ready;
    load      = strobe_rise & slot_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (load) begin
        tx_valid <= 1'b1;
        tx_data  <= data_q;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpt_printer_model.sv
module lpt_printer_model
  import lpt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_low,
  input  logic              busy_clr,
  input  logic              rd_status,
  input  logic              strobe_lvl,
  input  logic              byte_pending,
  input  logic              ien_nxt,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  logic [DATA_W-1:0] st_n;
  logic              flag_q;
  logic              flag_n;
  logic              can_step;

  always_comb begin
    st_n     = status_q;
    flag_n   = flag_q;
    can_step = ~status_q[ST_BUSY] & ~strobe_lvl & ~byte_pending;
    if (init_low) begin
      st_n = DATA_W'(ST_IDLE);
    end else if (busy_clr) begin
      st_n[ST_BUSY] = 1'b0;
    end else if (rd_status) begin
      flag_n = 1'b0;
      if (can_step) begin
        if (status_q[ST_ACK]) begin
          st_n[ST_ACK] = 1'b0;
          flag_n       = 1'b1;
        end else begin
          st_n[ST_ACK]  = 1'b1;
          st_n[ST_BUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= DATA_W'(ST_IDLE);
      flag_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      status_q <= st_n;
      flag_q   <= flag_n;
      irq      <= ien_nxt & flag_n;
    end
  end
endmodule

// File: rtl/lpt_read_mux.sv
module lpt_read_mux
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] pin_in,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DATA_W-1:0] status_q,
  input  logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [DATA_W-1:0] sel;

  always_comb begin
    case (addr)
      ADDR_W'(OFF_DATA): sel = ctrl_q[CT_DIR] ? pin_in : data_q;
      ADDR_W'(OFF_STAT): sel = status_q;
      ADDR_W'(OFF_CTRL): sel = {{PAD_W{1'b1}}, ctrl_q};
      default:           sel = {DATA_W{1'b1}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/lpt_port.sv
module lpt_port
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  logic              wr_data;
  logic              wr_ctrl;
  logic              rd_status;
  logic [DATA_W-1:0] data_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] status_q;
  logic              ien_nxt;
  logic              init_low;
  logic              busy_clr;
  logic              strobe_rise;

  always_comb begin
    wr_data   = wr_en & (addr == ADDR_W'(OFF_DATA));
    wr_ctrl   = wr_en & (addr == ADDR_W'(OFF_CTRL));
    rd_status = rd_en & (addr == ADDR_W'(OFF_STAT));
  end

  lpt_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .data_q(data_q), .ctrl_q(ctrl_q), .ien_nxt(ien_nxt), .init_low(init_low),
    .busy_clr(busy_clr), .strobe_rise(strobe_rise)
  );

  lpt_byte_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .strobe_rise(strobe_rise & ~init_low), .data_q(data_q),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  lpt_printer_model #(.DATA_W(DATA_W)) u_prn (
    .clk(clk), .rst(rst), .init_low(init_low), .busy_clr(busy_clr),
    .rd_status(rd_status), .strobe_lvl(ctrl_q[CT_STB]), .byte_pending(tx_valid),
    .ien_nxt(ien_nxt), .status_q(status_q), .irq(irq)
  );

  lpt_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .pin_in(pin_in),
    .data_q(data_q), .status_q(status_q), .ctrl_q(ctrl_q), .rdata(rdata)
  );
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] status_q
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

  AST_INIT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CTRL) && !wdata[CT_INIT]) |=> (status_q == DATA_W'(ST_IDLE))); // R4

  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CTRL) && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB])
    |=> !status_q[ST_BUSY]); // R5

  AST_BYTE_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(wr_en && addr == ADDR_W'(OFF_CTRL) && wdata[CT_STB] && !ctrl_q[CT_STB])); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl_q[CT_IEN]); // R8

  AST_UNUSED_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > ADDR_W'(OFF_CTRL)) |=> (rdata == {DATA_W{1'b1}})); // R10
endmodule

bind lpt_port lpt_port_chk u_chk (.*);

// File: tb/test_lpt_port.sv
module test_lpt_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin_in = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int n_acc = 0;
  logic [7:0] last_acc = '0;
  bit done = 0;

  always #10 clk = ~clk;

  lpt_port i_lpt_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      n_acc <= n_acc + 1;
      last_acc <= tx_data;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    rd_chk(3'd1, 8'hD8, "R1 R2 status reset");
    rd_chk(3'd2, 8'hCC, "R1 R3 control reset");
  endtask

  task automatic t_print_stall;
    tx_ready = 1'b0;
    bus_wr(3'd0, 8'h5A);
    bus_wr(3'd2, 8'h0D);
    check("R5 byte valid", {7'd0, tx_valid}, 8'h01);
    check("R5 byte data", tx_data, 8'h5A);
    rd_chk(3'd1, 8'h58, "R5 busy cleared");
    bus_wr(3'd2, 8'h0C);
    rd_chk(3'd1, 8'h58, "R7 no step while pending 1");
    rd_chk(3'd1, 8'h58, "R7 no step while pending 2");
    check("R7 held data", tx_data, 8'h5A);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R7 accepted count", 8'(n_acc), 8'd1);
    check("R7 accepted byte", last_acc, 8'h5A);
    check("R7 valid dropped", {7'd0, tx_valid}, 8'h00);
    rd_chk(3'd1, 8'h58, "R6 read before ack step");
    rd_chk(3'd1, 8'h18, "R6 ack cleared");
    rd_chk(3'd1, 8'hD8, "R6 ready restored");
    repeat (3) @(negedge clk);
    check("R11 rdata held", rdata, 8'hD8);
  endtask

  task automatic t_strobe_hold;
    int c0;
    tx_ready = 1'b1;
    c0 = n_acc;
    bus_wr(3'd0, 8'h11);
    bus_wr(3'd2, 8'h0D);
    repeat (2) @(negedge clk);
    check("R5 one byte sent", 8'(n_acc - c0), 8'd1);
    check("R5 byte value", last_acc, 8'h11);
    bus_wr(3'd0, 8'h22);
    bus_wr(3'd2, 8'h0D);
    repeat (2) @(negedge clk);
    check("R5 strobe held sends nothing", 8'(n_acc - c0), 8'd1);
    bus_wr(3'd2, 8'h0C);
    rd_chk(3'd1, 8'h58, "R6 step a");
    rd_chk(3'd1, 8'h18, "R6 step b");
    rd_chk(3'd1, 8'hD8, "R6 step c");
    bus_wr(3'd2, 8'h0E);
    rd_chk(3'd2, 8'hCE, "R3 autolf readback");
    bus_wr(3'd2, 8'h0C);
  endtask

  task automatic t_irq;
    tx_ready = 1'b1;
    bus_wr(3'd2, 8'h1C);
    bus_wr(3'd0, 8'h99);
    bus_wr(3'd2, 8'h1D);
    bus_wr(3'd2, 8'h1C);
    check("R8 irq idle", {7'd0, irq}, 8'h00);
    rd_chk(3'd1, 8'h58, "R8 status pre ack");
    check("R8 irq raised", {7'd0, irq}, 8'h01);
    rd_chk(3'd1, 8'h18, "R8 status after ack");
    check("R8 irq cleared by read", {7'd0, irq}, 8'h00);
    rd_chk(3'd1, 8'hD8, "R8 status idle");
    bus_wr(3'd2, 8'h0C);
    bus_wr(3'd2, 8'h0D);
    bus_wr(3'd2, 8'h0C);
    rd_chk(3'd1, 8'h58, "R8 status pre ack masked");
    check("R8 irq masked", {7'd0, irq}, 8'h00);
    bus_wr(3'd2, 8'h1C);
    check("R8 flag kept across enable", {7'd0, irq}, 8'h01);
    rd_chk(3'd1, 8'h18, "R8 status ack done");
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    rd_chk(3'd1, 8'hD8, "R8 status back idle");
    bus_wr(3'd2, 8'h0C);
  endtask

  task automatic t_init;
    int c0;
    tx_ready = 1'b1;
    bus_wr(3'd2, 8'h0D);
    bus_wr(3'd2, 8'h0C);
    rd_chk(3'd1, 8'h58, "R4 setup read");
    bus_wr(3'd2, 8'h08);
    rd_chk(3'd1, 8'hD8, "R4 init reloads status");
    c0 = n_acc;
    bus_wr(3'd2, 8'h09);
    repeat (2) @(negedge clk);
    check("R4 no byte under init", 8'(n_acc - c0), 8'd0);
    rd_chk(3'd1, 8'hD8, "R4 status stays idle");
    bus_wr(3'd2, 8'h0C);
  endtask

  task automatic t_dir;
    pin_in = 8'h3C;
    bus_wr(3'd0, 8'h77);
    bus_wr(3'd2, 8'h2C);
    rd_chk(3'd0, 8'h3C, "R9 input byte");
    pin_in = 8'hC3;
    rd_chk(3'd0, 8'hC3, "R9 input byte follows pins");
    bus_wr(3'd2, 8'h0C);
    rd_chk(3'd0, 8'h77, "R9 written byte");
  endtask

  task automatic t_unused;
    for (int a = 3; a < 8; a++) rd_chk(3'(a), 8'hFF, "R10 unused reads FF");
    for (int a = 5; a < 8; a++) bus_wr(3'(a), 8'h00);
    rd_chk(3'd0, 8'h77, "R10 data untouched");
    rd_chk(3'd1, 8'hD8, "R10 status untouched");
    rd_chk(3'd2, 8'hCC, "R10 control untouched");
  endtask

  task automatic t_collision;
    int c0;
    logic [7:0] v;
    tx_ready = 1'b0;
    bus_wr(3'd0, 8'hA1);
    bus_wr(3'd2, 8'h0D);
    bus_wr(3'd2, 8'h0C);
    bus_wr(3'd0, 8'hB2);
    c0 = n_acc;
    @(negedge clk);
    addr = 3'd2; wdata = 8'h0D; wr_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_ready = 1'b0;
    check("R7 old byte taken", 8'(n_acc - c0), 8'd1);
    check("R7 old byte value", last_acc, 8'hA1);
    check("R7 new byte pending", {7'd0, tx_valid}, 8'h01);
    check("R7 new byte value", tx_data, 8'hB2);
    bus_wr(3'd2, 8'h0C);
    bus_wr(3'd0, 8'hC3);
    bus_wr(3'd2, 8'h0D);
    check("R7 edge dropped while pending", tx_data, 8'hB2);
    bus_wr(3'd2, 8'h0C);
    @(negedge clk);
    addr = 3'd1; rd_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; tx_ready = 1'b0;
    v = rdata;
    check("R7 read in accept cycle", v, 8'h58);
    check("R7 byte gone", {7'd0, tx_valid}, 8'h00);
    rd_chk(3'd1, 8'h58, "R7 read in accept cycle did not step");
    rd_chk(3'd1, 8'h18, "R6 step after accept");
    rd_chk(3'd1, 8'hD8, "R6 idle after accept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_print_stall();
    t_strobe_hold();
    t_irq();
    t_init();
    t_dir();
    t_unused();
    t_collision();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule